// File: doc/BRIEF.md
# Register Write-Protection Key Gate

This block sits in front of the register file of a real-time clock peripheral and decides, write by write, whether a bus write may reach its target. Software opens the gate by writing two key bytes, in a fixed order, to a write-only key register. Any other value written there closes the gate again. While the gate is closed, writes to protected registers are dropped. A small set of registers stays writable regardless of the gate state.

The block sees the same write port as the register file: address, data and strobe. It returns a forwarded strobe and a per-bit write mask. The register file applies a write only when the forwarded strobe is high, and then only to the bits set in the mask. A read-data path is also routed through the block so that the key register always reads as zero. The gate state is available as a registered output.

Addresses are word indices. Their defaults are: key register 9, status register 3, tamper/alternate-function configuration register 16, and backup data registers 20 to 39.

Top module: `wp_key_gate`

## Requirements
- R1: After reset the gate is closed: `wr_allow_o` is 0 and the sequence waits for the first key.
- R2: The gate opens when key byte 0xCA is written to the key register and then key byte 0x53 is written to it. `wr_allow_o` goes to 1 in the cycle after the 0x53 write.
- R3: With the gate closed, a first key byte other than 0xCA leaves it closed. 0xCA followed by any byte other than 0x53 (0xCA included) returns to the closed idle state, so a lone 0x53 written afterwards does not open the gate.
- R4: While the gate is open, any write to the key register closes it, 0xFF being the usual relock value. If the byte written is 0xCA, it also counts as the first key of a new sequence.
- R5: Only data bits 7:0 of a key-register write form the key byte. Bits 31:8 are ignored.
- R6: Writes to any address other than the key register never change the gate state or the sequence progress.
- R7: A write to a protected register while the gate is closed gives `wr_en_o` = 0 and `wr_mask_o` = 0.
- R8: While the gate is open, a write to a protected register is forwarded with `wr_en_o` = 1 and an all-ones mask.
- R9: A write to the status register is always forwarded. The mask is 0x00003F00 (bits 13:8) while the gate is closed and all ones while it is open.
- R10: Writes to the tamper configuration register and to the backup data registers are forwarded with an all-ones mask whatever the gate state.
- R11: Key-register writes are never forwarded. A read of the key address returns 0 on `rd_data_o`; a read of any other address returns `rd_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 6 | Bus write word address |
| wr_data_i | input | 32 | Bus write data |
| rd_addr_i | input | 6 | Bus read word address |
| rd_data_i | input | 32 | Read data from the register file |
| wr_en_o | output | 1 | Write strobe forwarded to the register file |
| wr_mask_o | output | 32 | Bits the forwarded write may change |
| rd_data_o | output | 32 | Read data returned to the bus |
| wr_allow_o | output | 1 | Registered gate state, 1 = open |

## Verification
The bench targets the sequence corners. A second key of 0xCA must return the sequence to idle rather than restart it; a design that restarts would open on a following lone 0x53. A key byte with 0xCA or 0x53 in its low bits and noise above must still count; a design that compares the full word would never open on it. A key write while open must close the gate; a design that ignores it would leave protected registers exposed. The exemptions are checked in both gate states. A status write while closed must carry only bits 13:8, which catches a design that forwards the full mask or drops the write. Backup and tamper writes must pass while closed, which catches a design that locks them.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_HALF   = 2'd1,
    ST_OPEN   = 2'd2
  } seq_st_e;

  typedef enum logic [1:0] {
    CLS_PROT = 2'd0,
    CLS_KEY  = 2'd1,
    CLS_STAT = 2'd2,
    CLS_FREE = 2'd3
  } addr_cls_e;
endpackage

// File: rtl/wpk_addr_dec.sv
module wpk_addr_dec
  import wpk_pkg::*;
#(
  parameter int AW        = 6,
  parameter int KEY_ADDR  = 9,
  parameter int STAT_ADDR = 3,
  parameter int TAMP_ADDR = 16,
  parameter int BKP_BASE  = 20,
  parameter int BKP_NUM   = 20
) (
  input  logic [AW-1:0] addr_i,
  output addr_cls_e     cls_o
);
  localparam int BKP_LAST = BKP_BASE + BKP_NUM - 1;

  logic bkp_hit;

  generate
    if (BKP_NUM > 0) begin : g_bkp
      always_comb bkp_hit = (int'(addr_i) >= BKP_BASE) && (int'(addr_i) <= BKP_LAST);
    end else begin : g_no_bkp
      always_comb bkp_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    if (int'(addr_i) == KEY_ADDR)                   cls_o = CLS_KEY;
    else if (int'(addr_i) == STAT_ADDR)             cls_o = CLS_STAT;
    else if (int'(addr_i) == TAMP_ADDR || bkp_hit)  cls_o = CLS_FREE;
    else                                            cls_o = CLS_PROT;
  end
endmodule

// File: rtl/wpk_seq_fsm.sv
module wpk_seq_fsm
  import wpk_pkg::*;
#(
  parameter int          KEY_W = 8,
  parameter logic [7:0]  KEY1  = 8'hCA,
  parameter logic [7:0]  KEY2  = 8'h53
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             open_o
);
  localparam logic [KEY_W-1:0] K1 = KEY_W'(KEY1);
  localparam logic [KEY_W-1:0] K2 = KEY_W'(KEY2);

  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_wr_i) begin
      unique case (st_q)
        ST_HALF: st_d = (key_i == K2) ? ST_OPEN : ST_LOCKED;
        default: st_d = (key_i == K1) ? ST_HALF : ST_LOCKED;  // open: any key relocks
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_LOCKED;
    else         st_q <= st_d;
  end

  assign open_o = (st_q == ST_OPEN);

  // R2
  open_needs_key2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(key_wr_i && key_i == K2));
  // R6
  open_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && !key_wr_i) |=> open_o);
  // R4
  key_relocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && key_wr_i) |=> !open_o);
  // R3
  bad_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HALF && key_wr_i && key_i != K2) |=> st_q == ST_LOCKED);
endmodule

// File: rtl/wp_key_gate.sv
module wp_key_gate
  import wpk_pkg::*;
#(
  parameter int          AW            = 6,
  parameter int          DW            = 32,
  parameter int          KEY_W         = 8,
  parameter logic [7:0]  KEY1          = 8'hCA,
  parameter logic [7:0]  KEY2          = 8'h53,
  parameter int          KEY_ADDR      = 9,
  parameter int          STAT_ADDR     = 3,
  parameter int          TAMP_ADDR     = 16,
  parameter int          BKP_BASE      = 20,
  parameter int          BKP_NUM       = 20,
  parameter logic [31:0] STAT_FREE_MSK = 32'h0000_3F00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_mask_o,
  output logic [DW-1:0] rd_data_o,
  output logic          wr_allow_o
);
  localparam logic [DW-1:0] FULL_MSK = '1;
  localparam logic [DW-1:0] STAT_MSK = DW'(STAT_FREE_MSK);

  addr_cls_e wr_cls, rd_cls;
  logic      open;

  wpk_addr_dec #(
    .AW(AW), .KEY_ADDR(KEY_ADDR), .STAT_ADDR(STAT_ADDR),
    .TAMP_ADDR(TAMP_ADDR), .BKP_BASE(BKP_BASE), .BKP_NUM(BKP_NUM)
  ) u_wr_dec (.addr_i(wr_addr_i), .cls_o(wr_cls));

  wpk_addr_dec #(
    .AW(AW), .KEY_ADDR(KEY_ADDR), .STAT_ADDR(STAT_ADDR),
    .TAMP_ADDR(TAMP_ADDR), .BKP_BASE(BKP_BASE), .BKP_NUM(BKP_NUM)
  ) u_rd_dec (.addr_i(rd_addr_i), .cls_o(rd_cls));

  wpk_seq_fsm #(.KEY_W(KEY_W), .KEY1(KEY1), .KEY2(KEY2)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_wr_i (wr_en_i && wr_cls == CLS_KEY),
    .key_i    (wr_data_i[KEY_W-1:0]),
    .open_o   (open)
  );

  always_comb begin
    wr_en_o   = 1'b0;
    wr_mask_o = '0;
    if (wr_en_i) begin
      unique case (wr_cls)
        CLS_KEY: ;
        CLS_FREE: begin
          wr_en_o   = 1'b1;
          wr_mask_o = FULL_MSK;
        end
        CLS_STAT: begin
          wr_en_o   = 1'b1;
          wr_mask_o = open ? FULL_MSK : STAT_MSK;
        end
        default: begin
          wr_en_o   = open;
          wr_mask_o = open ? FULL_MSK : '0;
        end
      endcase
    end
  end

  assign rd_data_o  = (rd_cls == CLS_KEY) ? '0 : rd_data_i;
  assign wr_allow_o = open;

  // R11
  key_not_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(wr_addr_i) == KEY_ADDR) |-> !wr_en_o);
  // R9
  stat_locked_msk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && int'(wr_addr_i) == STAT_ADDR && (wr_mask_o & ~STAT_MSK) != '0) |-> wr_allow_o);
  // R11
  key_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rd_addr_i) == KEY_ADDR) |-> rd_data_o == '0);
  // R10
  free_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(wr_addr_i) == TAMP_ADDR) |-> (wr_en_o && wr_mask_o == FULL_MSK));
endmodule

// File: tb/wp_key_gate_tb_top.sv
module wp_key_gate_tb_top;
  localparam int KEYA = 9, STATA = 3, TAMPA = 16, BKPB = 20, BKPN = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [5:0]  rd_addr_i = '0;
  logic [31:0] rd_data_i = '0;
  logic        wr_en_o;
  logic [31:0] wr_mask_o;
  logic [31:0] rd_data_o;
  logic        wr_allow_o;

  int total = 0;
  int bad = 0;
  int mst = 0;   // 0 locked, 1 first key seen, 2 open
  bit done = 0;

  always #4 clk_i = ~clk_i;

  wp_key_gate dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_i, .wr_en_o, .wr_mask_o, .rd_data_o, .wr_allow_o
  );

  function automatic bit is_free(int a);
    return a == TAMPA || (a >= BKPB && a < BKPB + BKPN);
  endfunction

  function automatic bit exp_en(int a, bit open);
    if (a == KEYA) return 0;
    if (a == STATA || is_free(a)) return 1;
    return open;
  endfunction

  function automatic logic [31:0] exp_msk(int a, bit open);
    if (a == KEYA) return '0;
    if (is_free(a)) return '1;
    if (a == STATA) return open ? 32'hFFFF_FFFF : 32'h0000_3F00;
    return open ? 32'hFFFF_FFFF : '0;
  endfunction

  function automatic int next_st(int s, logic [7:0] k);
    if (s == 1) return (k == 8'h53) ? 2 : 0;
    return (k == 8'hCA) ? 1 : 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one write cycle with a read alongside; checks comb outputs, then state
  task automatic wr(int a, logic [31:0] d, string req);
    logic [31:0] rv;
    int ra;
    @(negedge clk_i);
    chk({req, " allow"}, {31'd0, wr_allow_o}, {31'd0, mst == 2});
    ra = ($urandom % 4 == 0) ? KEYA : int'($urandom % 64);
    rv = $urandom;
    wr_en_i = 1'b1; wr_addr_i = 6'(a); wr_data_i = d;
    rd_addr_i = 6'(ra); rd_data_i = rv;
    #1;
    chk({req, " en"}, {31'd0, wr_en_o}, {31'd0, exp_en(a, mst == 2)});
    chk({req, " msk"}, wr_mask_o, exp_msk(a, mst == 2));
    chk("R11 rd", rd_data_o, (ra == KEYA) ? 32'd0 : rv);
    @(posedge clk_i);
    if (a == KEYA) mst = next_st(mst, d[7:0]);
    #1 wr_en_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #20 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset allow", {31'd0, wr_allow_o}, 32'd0);
    wr(5, 32'h1234, "R7 locked prot");
    wr(STATA, '1, "R9 locked stat");
    wr(TAMPA, '1, "R10 tamper locked");
    wr(BKPB + BKPN - 1, '1, "R10 bkp locked");
    wr(KEYA, 32'h53, "R3 lone second");
    wr(KEYA, 32'hCA, "R2 first");
    wr(7, 32'h0, "R6 between");
    wr(KEYA, 32'hCA, "R3 ca twice");
    wr(KEYA, 32'h53, "R3 no open");
    wr(KEYA, 32'hABCD_00CA, "R5 first hi bits");
    wr(KEYA, 32'h7700_0153, "R5 second hi bits");
    wr(5, '1, "R8 open prot");
    wr(STATA, '1, "R9 open stat");
    wr(40, '1, "R6 open other");
    wr(KEYA, 32'hFF, "R4 relock");
    wr(5, '1, "R7 after relock");
    wr(KEYA, 32'hCA, "R2 again1");
    wr(KEYA, 32'h53, "R2 again2");
    wr(KEYA, 32'hCA, "R4 ca while open");
    wr(KEYA, 32'h53, "R4 ca restarts");
    wr(6, '1, "R8 reopen");
    for (int i = 0; i < 600; i++) begin
      int a;
      logic [31:0] d;
      int p = $urandom % 8;
      d = $urandom;
      if (p < 4) begin
        a = KEYA;
        if (p == 0) d[7:0] = 8'hCA;
        else if (p == 1) d[7:0] = 8'h53;
        else if (p == 2) d[7:0] = 8'hFF;
      end else if (p == 4) a = STATA;
      else a = int'($urandom % 64);
      wr(a, d, "R6 random");
    end
    @(negedge clk_i);
    chk("R2 final allow", {31'd0, wr_allow_o}, {31'd0, mst == 2});
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule